// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is the bus-facing controller of a small byte-addressed nonvolatile memory reached over a two-wire serial bus (clock plus open-drain data). It watches the bus for START and STOP conditions and answers a select byte whose fixed upper nibble is `1010`. The select byte carries strap or page bits and a read/write flag. A word address follows, and then data moves in one of two directions. On a write the bytes go into a page buffer. A STOP commits the buffer into the internal array and begins a self-timed write cycle. During that cycle the device ignores its own select byte.

Reads come in three forms. A random read is a dummy write of the address followed by a repeated START. A current-address read continues from the internal pointer. A sequential read lets the master acknowledge each byte to stream the next. A write-protect input stops every commit. Both bus lines pass through a sampling glitch filter before any decoding. The array density is a parameter, and the address width, page size and number of compared strap bits all follow from it. The self-timed write length is a parameter counted in clock cycles.

Top module: `tw_eeprom_slave`

## Requirements
- R1: The block never drives SDA high. `sda_oe` = 1 pulls the line low and 0 releases it. `sda_oe` changes only while the filtered SCL is low, after a falling edge. It is 0 after reset and after every completed transfer.
- R2: The select byte is sent MSB first and has the layout bits[7:4] = `1010`, bits[3:1] = strap bits (bit 3 against `strap_i[2]`), bit 0 = 1 for read. With the default 256-byte density all three strap bits are compared. On any mismatch the select byte gets no ACK (SDA stays high in the ninth clock).
- R3: A write transfer (select with bit 0 = 0, word address, data byte, STOP) ACKs every byte and stores the data at that address.
- R4: A partial page write of 1 up to page-size bytes stores exactly the bytes sent. All other bytes of that page keep their old values. The page is 8 bytes at 128/256 bytes of density and 16 bytes above that.
- R5: Within one write transfer the address advances only in its low page bits and wraps inside the page. Bytes beyond the page size overwrite earlier bytes of the same transfer.
- R6: A random read (write select, word address, repeated START, read select) returns the byte stored at that address, MSB first.
- R7: A current-address read (START, read select) returns the byte after the last one read.
- R8: While the master ACKs, a sequential read increments the address across the whole array and rolls over from the last location to 0. A master NACK ends the read.
- R9: A STOP that ends a write holding at least one data byte starts a write cycle of `WR_CYCLES` clocks. During that cycle a matching select byte is not ACKed. Once it ends, the select byte is ACKed again.
- R10: While `wp_i` = 1, data bytes are still ACKed, but the STOP stores nothing and starts no write cycle, so the next select byte is ACKed at once.
- R11: A pulse on SCL or SDA shorter than `FILT_DEPTH` clocks is ignored and is never seen as an edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sampled level of the shared data line |
| sda_oe | output | 1 | Drive-low enable for the data line |
| strap_i | input | 3 | Device strap levels ([2] is the highest) |
| wp_i | input | 1 | Write protect, 1 blocks every commit |

## Verification
The checker assumes a master that obeys the bus protocol. SDA changes only while SCL is low, except when the master issues START or STOP. Each SCL level is held well past the filter depth. The master never issues START or STOP while the device is pulling SDA low, and it ends every read with a NACK before STOP. The bench master keeps to this by holding every SCL phase for two quarter-bits of eight clocks and moving its data line only a quarter-bit after SCL falls. It probes the busy state only with write selects, and it breaks the protocol only through one-clock SDA pulses that fall inside the filter window.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DACK,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } tw_state_e;

endpackage

// File: rtl/tw_filter.sv
module tw_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);

  logic [DEPTH-1:0] hist_q, hist_d;
  logic             filt_q, filt_d;

  always_comb begin
    hist_d = {hist_q[DEPTH-2:0], raw_i};
    filt_d = filt_q;
    if (&hist_q)       filt_d = 1'b1;
    else if (~|hist_q) filt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
  parameter int PAGE = 8,
  parameter int PW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PW-1:0]     off_i,
  input  logic [7:0]        data_i,
  output logic [PAGE*8-1:0] data_o,
  output logic [PAGE-1:0]   valid_o
);

  logic [PAGE-1:0] valid_q;

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic [7:0] byte_q;
    logic       hit;

    assign hit = wr_i && (off_i == PW'(g));

    always_ff @(posedge clk) begin
      if (hit) byte_q <= data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q[g] <= 1'b0;
      else if (clr_i) valid_q[g] <= 1'b0;
      else if (hit)   valid_q[g] <= 1'b1;
    end

    assign data_o[g*8 +: 8] = byte_q;
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/tw_nvm_array.sv
module tw_nvm_array #(
  parameter int MEM_BYTES = 256,
  parameter int AW        = 8,
  parameter int PAGE      = 8,
  parameter int PW        = 3,
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [AW-PW-1:0]  page_i,
  input  logic [PAGE*8-1:0] pdata_i,
  input  logic [PAGE-1:0]   pvalid_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);

  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [7:0]    mem [MEM_BYTES];
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk) begin
    if (commit_i) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pvalid_i[i]) mem[{page_i, PW'(i)}] <= pdata_i[i*8 +: 8];
      end
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (commit_i)          cnt_d = CW'(WR_CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o    = (cnt_q != '0);
  assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
  parameter int MEM_BYTES  = 256,
  parameter int WR_CYCLES  = 250000,
  parameter int FILT_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  import tw_pkg::*;

  localparam int AW      = $clog2(MEM_BYTES);
  localparam int PAGE    = (MEM_BYTES <= 256) ? 8 : 16;
  localparam int PW      = $clog2(PAGE);
  localparam int NPB     = AW - PW;
  localparam int STRAP_N = (AW <= 8) ? 3 : (11 - AW);
  localparam int HI_N    = 3 - STRAP_N;

  // line filtering
  logic [1:0] raw_v, filt_v;
  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    tw_filter #(.DEPTH(FILT_DEPTH)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_v[g]),
      .filt_o (filt_v[g])
    );
  end

  logic scl_f, sda_f, scl_d, sda_d;
  logic scl_rise, scl_fall, start_c, stop_c;

  assign scl_f = filt_v[0];
  assign sda_f = filt_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  // state
  tw_state_e     state_q, state_d;
  logic [2:0]    bit_q, bit_d;
  logic          done_q, done_d;
  logic [7:0]    sh_q, sh_d;
  logic [7:0]    rbyte_q, rbyte_d;
  logic          oe_q, oe_d;
  logic          rw_q, rw_d;
  logic          mack_q, mack_d;
  logic          wrote_q, wrote_d;
  logic [AW-1:0] ptr_q, ptr_d;

  logic              busy;
  logic [7:0]        rd_data;
  logic              pb_clr, pb_wr, commit;
  logic [PAGE*8-1:0] pb_data;
  logic [PAGE-1:0]   pb_valid;
  logic [NPB-1:0]    page_q;

  assign page_q = ptr_q[AW-1:PW];

  // select decode and address assembly
  logic [2:0]    strap_ok;
  logic          sel_match;
  logic [AW-1:0] addr_from_word, addr_from_sel;

  for (genvar gi = 0; gi < 3; gi++) begin : g_strap
    if (gi >= HI_N) begin : g_cmp
      assign strap_ok[gi] = (sh_q[gi+1] == strap_i[gi]);
    end else begin : g_page
      assign strap_ok[gi] = 1'b1;
    end
  end

  assign sel_match = (sh_q[7:4] == 4'b1010) && (&strap_ok);

  for (genvar gb = 0; gb < AW; gb++) begin : g_abit
    if (gb < 8) begin : g_lo
      assign addr_from_word[gb] = sh_q[gb];
      assign addr_from_sel[gb]  = ptr_q[gb];
    end else begin : g_hi
      assign addr_from_word[gb] = ptr_q[gb];
      assign addr_from_sel[gb]  = sh_q[gb-7];
    end
  end

  // next state
  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    done_d  = done_q;
    sh_d    = sh_q;
    rbyte_d = rbyte_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    wrote_d = wrote_q;
    ptr_d   = ptr_q;
    pb_clr  = 1'b0;
    pb_wr   = 1'b0;
    commit  = 1'b0;

    if (start_c) begin
      state_d = ST_DEV;
      bit_d   = '0;
      done_d  = 1'b0;
      oe_d    = 1'b0;
      wrote_d = 1'b0;
      pb_clr  = 1'b1;
    end else if (stop_c) begin
      commit  = wrote_q && !wp_i;
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      done_d  = 1'b0;
      wrote_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_f};
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) done_d = 1'b1;
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            bit_d  = '0;
            if (state_q == ST_DEV) begin
              if (sel_match && !busy) begin
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                state_d = ST_DACK;
                if (!sh_q[0]) ptr_d = addr_from_sel;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_ADDR) begin
              ptr_d   = addr_from_word;
              oe_d    = 1'b1;
              state_d = ST_AACK;
            end else begin
              pb_wr   = 1'b1;
              ptr_d   = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};
              wrote_d = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_WACK;
            end
          end
        end
        ST_DACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              rbyte_d = rd_data;
              oe_d    = ~rd_data[7];
              state_d = ST_RDAT;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_ADDR;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              oe_d    = 1'b0;
              ptr_d   = ptr_q + AW'(1);
              mack_d  = 1'b0;
              state_d = ST_RACK;
            end else begin
              rbyte_d = {rbyte_q[6:0], 1'b0};
              oe_d    = ~rbyte_q[6];
              bit_d   = bit_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_f) state_d = ST_IDLE;
            else       mack_d  = 1'b1;
          end else if (scl_fall && mack_q) begin
            rbyte_d = rd_data;
            oe_d    = ~rd_data[7];
            bit_d   = '0;
            state_d = ST_RDAT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
      sh_q    <= '0;
      rbyte_q <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      wrote_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
      sh_q    <= sh_d;
      rbyte_q <= rbyte_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      wrote_q <= wrote_d;
      ptr_q   <= ptr_d;
    end
  end

  assign sda_oe = oe_q;

  tw_page_buf #(.PAGE(PAGE), .PW(PW)) u_pbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (pb_clr),
    .wr_i    (pb_wr),
    .off_i   (ptr_q[PW-1:0]),
    .data_i  (sh_q),
    .data_o  (pb_data),
    .valid_o (pb_valid)
  );

  tw_nvm_array #(
    .MEM_BYTES (MEM_BYTES),
    .AW        (AW),
    .PAGE      (PAGE),
    .PW        (PW),
    .WR_CYCLES (WR_CYCLES)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .page_i    (page_q),
    .pdata_i   (pb_data),
    .pvalid_i  (pb_valid),
    .rd_addr_i (ptr_q),
    .rd_data_o (rd_data),
    .busy_o    (busy)
  );

endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk #(
  parameter int NPB = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              sda_oe,
  input logic              busy,
  input logic              wp_i,
  input tw_pkg::tw_state_e state,
  input logic [NPB-1:0]    page_q
);
  import tw_pkg::*;

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f); // R1

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state != ST_IDLE)); // R2

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WDAT || state == ST_WACK) &&
     ($past(state) == ST_WDAT || $past(state) == ST_WACK)) |-> $stable(page_q)); // R5

  AST_BUSY_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state != ST_DACK)); // R9

  AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i)); // R10

endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk #(.NPB(NPB)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_f  (scl_f),
  .sda_oe (sda_oe),
  .busy   (busy),
  .wp_i   (wp_i),
  .state  (state_q),
  .page_q (page_q)
);

// File: tb/tw_eeprom_slave_bench.sv
module tw_eeprom_slave_bench;

  localparam int CLK_P = 10;
  localparam int MEMB  = 256;
  localparam int WRC   = 400;
  localparam int Q     = 8;
  localparam logic [2:0] STRAP = 3'b101;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] d;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h00, 8'h3C}, '{8'h7F, 8'hA5}, '{8'h80, 8'h5A},
    '{8'hFF, 8'h11}, '{8'h30, 8'hC3}, '{8'hA5, 8'h96}
  };

  logic clk, rst_n, scl_m, sda_m, wp;
  logic sda_oe, sda_line;
  int   errs, checks;

  logic [7:0] mdl  [MEMB];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  assign sda_line = sda_m & ~sda_oe;

  tw_eeprom_slave #(
    .MEM_BYTES  (MEMB),
    .WR_CYCLES  (WRC),
    .FILT_DEPTH (3)
  ) u_tw_eeprom_slave (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_line),
    .sda_oe  (sda_oe),
    .strap_i (STRAP),
    .wp_i    (wp)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = b[i]; tick(Q); scl_m = 1'b1;
      if (glitch && i == 4) begin
        tick(Q/2); sda_m = ~sda_m; tick(1); sda_m = ~sda_m; tick(2*Q - Q/2 - 1);
      end else begin
        tick(2*Q);
      end
      scl_m = 1'b0;
    end
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); ack = !sda_line; tick(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  function automatic logic [7:0] sel(input bit rd);
    return {4'b1010, STRAP, rd};
  endfunction

  // write n bytes from wbuf starting at a; model follows R5 page wrap and R10
  task automatic write_seq(input logic [7:0] a, input int n, input bit glitch, output bit all_ack);
    bit k_ack;
    all_ack = 1'b1;
    bus_start();
    send_byte(sel(1'b0), 1'b0, k_ack); all_ack &= k_ack;
    send_byte(a, 1'b0, k_ack);         all_ack &= k_ack;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], glitch, k_ack); all_ack &= k_ack;
      if (!wp) mdl[{a[7:3], 3'(a[2:0] + 3'(k))}] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic read_rand(input logic [7:0] a, input int n);
    bit k_ack;
    bus_start();
    send_byte(sel(1'b0), 1'b0, k_ack);
    send_byte(a, 1'b0, k_ack);
    bus_start();
    send_byte(sel(1'b1), 1'b0, k_ack);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic probe(output bit ack);
    bus_start();
    send_byte(sel(1'b0), 1'b0, ack);
    bus_stop();
  endtask

  task automatic wait_write();
    tick(WRC + 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit ok;
    logic [7:0] b;
    errs = 0; checks = 0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);

    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // R2: wrong fixed nibble, wrong strap
    bus_start(); send_byte(8'b1011_1010, 1'b0, ok); bus_stop();
    chk(!ok, "R2 wrong nibble ack", ok, 0);
    bus_start(); send_byte({4'b1010, 3'b100, 1'b0}, 1'b0, ok); bus_stop();
    chk(!ok, "R2 wrong strap ack", ok, 0);
    probe(ok);
    chk(ok, "R2 matching select ack", ok, 1);

    // R3/R6: vector walk of byte writes and random reads
    foreach (VECS[v]) begin
      wbuf[0] = VECS[v].d;
      write_seq(VECS[v].a, 1, 1'b0, ok);
      chk(ok, "R3 write acks", ok, 1);
      wait_write();
      read_rand(VECS[v].a, 1);
      chk(rbuf[0] == VECS[v].d, "R6 random read", rbuf[0], VECS[v].d);
      chk(sda_oe == 1'b0, "R1 released after read", sda_oe, 0);
    end

    // R9: busy after a write
    wbuf[0] = 8'h77;
    write_seq(8'h10, 1, 1'b0, ok);
    probe(ok);
    chk(!ok, "R9 select during write cycle", ok, 0);
    wait_write();
    probe(ok);
    chk(ok, "R9 select after write cycle", ok, 1);

    // R4: full page then partial page
    for (int k = 0; k < 8; k++) wbuf[k] = 8'h20 + 8'(k);
    write_seq(8'h40, 8, 1'b0, ok); wait_write();
    for (int k = 0; k < 3; k++) wbuf[k] = 8'hE0 + 8'(k);
    write_seq(8'h42, 3, 1'b0, ok); wait_write();
    read_rand(8'h40, 8);
    for (int k = 0; k < 8; k++)
      chk(rbuf[k] == mdl[8'h40 + k], "R4 partial page", rbuf[k], mdl[8'h40 + k]);

    // R5: ten bytes from offset 6 wrap in the page
    for (int k = 0; k < 10; k++) wbuf[k] = 8'h60 + 8'(k);
    write_seq(8'h56, 10, 1'b0, ok);
    chk(ok, "R5 wrap acks", ok, 1);
    wait_write();
    read_rand(8'h50, 8);
    for (int k = 0; k < 8; k++)
      chk(rbuf[k] == mdl[8'h50 + k], "R5 page wrap", rbuf[k], mdl[8'h50 + k]);

    // R7: current-address read after a one-byte random read of 0x7F
    read_rand(8'h7F, 1);
    bus_start(); send_byte(sel(1'b1), 1'b0, ok); recv_byte(1'b0, b); bus_stop();
    chk(ok, "R7 read select ack", ok, 1);
    chk(b == mdl[8'h80], "R7 current address", b, mdl[8'h80]);

    // R8: sequential rollover 0xFF -> 0x00
    read_rand(8'hFF, 2);
    chk(rbuf[0] == mdl[8'hFF], "R8 last location", rbuf[0], mdl[8'hFF]);
    chk(rbuf[1] == mdl[8'h00], "R8 rollover", rbuf[1], mdl[8'h00]);

    // R10: write protect
    wp = 1'b1;
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    write_seq(8'h40, 2, 1'b0, ok);
    chk(ok, "R10 data acked while protected", ok, 1);
    probe(ok);
    chk(ok, "R10 no write cycle", ok, 1);
    wp = 1'b0;
    read_rand(8'h40, 2);
    chk(rbuf[0] == mdl[8'h40], "R10 byte 0 kept", rbuf[0], mdl[8'h40]);
    chk(rbuf[1] == mdl[8'h41], "R10 byte 1 kept", rbuf[1], mdl[8'h41]);

    // R11: one-clock SDA pulse while SCL high inside a data byte
    wbuf[0] = 8'h5E;
    write_seq(8'h31, 1, 1'b1, ok);
    chk(ok, "R11 acks with glitch", ok, 1);
    wait_write();
    read_rand(8'h31, 1);
    chk(rbuf[0] == 8'h5E, "R11 glitch ignored", rbuf[0], 8'h5E);

    finish_run();
  end

endmodule